// File: doc/BRIEF.md
# Bypassable Request/Response Queue Pair

This block sits on a point-to-point link between one bus host and one bus device. It holds two independent synchronous queues. The forward queue carries requests from the host to the device, and a narrow sideband field travels with each request. The return queue carries responses from the device back to the host. Each side of each direction uses a valid/ready handshake, and a transfer takes place in any cycle where both valid and ready are high.

Each direction has two settings of its own: a pass-through flag and a depth from 0 to 16. With pass-through on and its queue empty, an offered entry reaches the output in the same cycle. It is written into storage only if the output does not take it in that cycle. With pass-through off, every entry spends at least one cycle in storage. A depth of zero turns a direction into plain wires, and this is legal only with pass-through on. The block uses a synchronous reset, active low, that empties both queues.

Top module: `bypass_fifo_pair`

## Requirements
- R1: While `rst_n` is low, both output valids and both input readies are low. After reset is released and nothing is offered, both output valids stay low.
- R2: With pass-through on and the queue empty, an offered entry appears on that direction's output in the same cycle with the same data. On the request side the sideband value comes out with it.
- R3: With pass-through off, an entry accepted in cycle N is first visible at the output in cycle N+1.
- R4: Each direction delivers the entries it accepts in order of acceptance. Under any pattern of downstream readiness, no entry is lost or delivered twice.
- R5: For a non-zero depth D, input ready is low exactly when the direction holds D entries.
- R6: In pass-through mode, an entry that is taken at the output in the same cycle it is offered is not also stored. In the next cycle the output valid is low unless a new entry is offered.
- R7: At depth 0, the output follows the input unchanged, and input ready equals the downstream ready.
- R8: The request sideband field is queued with its request and leaves with it.
- R9: The two directions are independent. A full, stalled response queue does not change request pass-through behaviour.
- R10: A direction built with depth 16 accepts exactly 16 entries while stalled, refuses the 17th, and then drains all 16 in order.
- R11: While a stored entry is valid and not accepted, the output stays valid with unchanged data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_in_valid | input | 1 | Host offers a request |
| req_in_ready | output | 1 | Request queue can accept |
| req_in_data | input | REQ_W | Request payload from the host |
| req_in_spare | input | SPARE_W | Sideband bits carried with the request |
| req_out_valid | output | 1 | Request available to the device |
| req_out_ready | input | 1 | Device takes the request |
| req_out_data | output | REQ_W | Request payload to the device |
| req_out_spare | output | SPARE_W | Sideband bits leaving with the request |
| rsp_in_valid | input | 1 | Device offers a response |
| rsp_in_ready | output | 1 | Response queue can accept |
| rsp_in_data | input | RSP_W | Response payload from the device |
| rsp_out_valid | output | 1 | Response available to the host |
| rsp_out_ready | input | 1 | Host takes the response |
| rsp_out_data | output | RSP_W | Response payload to the host |

## Verification
Ordering is driven by streams of numbered entries under three downstream patterns: always ready, ready every other cycle, and ready one cycle in three. The first pattern exercises the same-cycle bypass path. The other two force entries through storage and around the pointer wrap, including non-power-of-two depths. Single-entry probes separate same-cycle pass-through from the one-cycle registered path. Fill-to-full runs at depths 3 and 16 check the exact point at which ready drops. A second instance built with a zero-depth request side shows that this side behaves as wires.

// File: rtl/bypass_fifo_pair.sv
`timescale 1ns/1ps
module bypass_fifo_pair #(
  parameter int unsigned REQ_W     = 8,
  parameter int unsigned RSP_W     = 8,
  parameter int unsigned SPARE_W   = 1,
  parameter bit          REQ_PASS  = 1'b1,
  parameter bit          RSP_PASS  = 1'b0,
  parameter int unsigned REQ_DEPTH = 2,
  parameter int unsigned RSP_DEPTH = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_in_valid,
  output logic               req_in_ready,
  input  logic [REQ_W-1:0]   req_in_data,
  input  logic [SPARE_W-1:0] req_in_spare,
  output logic               req_out_valid,
  input  logic               req_out_ready,
  output logic [REQ_W-1:0]   req_out_data,
  output logic [SPARE_W-1:0] req_out_spare,
  input  logic               rsp_in_valid,
  output logic               rsp_in_ready,
  input  logic [RSP_W-1:0]   rsp_in_data,
  output logic               rsp_out_valid,
  input  logic               rsp_out_ready,
  output logic [RSP_W-1:0]   rsp_out_data
);
  localparam int unsigned QW = REQ_W + SPARE_W;

  logic [QW-1:0] rq_in, rq_out;
  assign rq_in = {req_in_spare, req_in_data};
  assign {req_out_spare, req_out_data} = rq_out;

  if (REQ_DEPTH > 16 || (REQ_DEPTH == 0 && !REQ_PASS)) begin : g_req_bad
    $error("request side: depth must be 0..16, and 0 needs pass-through");
  end
  if (RSP_DEPTH > 16 || (RSP_DEPTH == 0 && !RSP_PASS)) begin : g_rsp_bad
    $error("response side: depth must be 0..16, and 0 needs pass-through");
  end

  if (REQ_DEPTH == 0) begin : g_req_wire
    assign req_out_valid = rst_n & req_in_valid;
    assign rq_out        = rq_in;
    assign req_in_ready  = rst_n & req_out_ready;
  end else begin : g_req_q
    localparam int unsigned AW = (REQ_DEPTH > 1) ? $clog2(REQ_DEPTH) : 1;
    localparam int unsigned CW = $clog2(REQ_DEPTH + 1);
    logic [QW-1:0] mem [REQ_DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic empty, full, thru, push, pop;

    assign empty         = (cnt == '0);
    assign full          = (cnt == CW'(REQ_DEPTH));
    assign thru          = REQ_PASS & empty;
    assign req_out_valid = rst_n & (thru ? req_in_valid : !empty);
    assign rq_out        = thru ? rq_in : mem[rp];
    assign req_in_ready  = rst_n & !full;
    assign push = req_in_valid & req_in_ready & !(thru & req_out_ready);
    assign pop  = req_out_valid & req_out_ready & !empty;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (push) wp <= (wp == AW'(REQ_DEPTH - 1)) ? '0 : wp + 1'b1;
        if (pop)  rp <= (rp == AW'(REQ_DEPTH - 1)) ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(push) - CW'(pop);
      end
    end

    always_ff @(posedge clk) begin
      if (push) mem[wp] <= rq_in;
    end
  end

  if (RSP_DEPTH == 0) begin : g_rsp_wire
    assign rsp_out_valid = rst_n & rsp_in_valid;
    assign rsp_out_data  = rsp_in_data;
    assign rsp_in_ready  = rst_n & rsp_out_ready;
  end else begin : g_rsp_q
    localparam int unsigned AW = (RSP_DEPTH > 1) ? $clog2(RSP_DEPTH) : 1;
    localparam int unsigned CW = $clog2(RSP_DEPTH + 1);
    logic [RSP_W-1:0] mem [RSP_DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic empty, full, thru, push, pop;

    assign empty         = (cnt == '0);
    assign full          = (cnt == CW'(RSP_DEPTH));
    assign thru          = RSP_PASS & empty;
    assign rsp_out_valid = rst_n & (thru ? rsp_in_valid : !empty);
    assign rsp_out_data  = thru ? rsp_in_data : mem[rp];
    assign rsp_in_ready  = rst_n & !full;
    assign push = rsp_in_valid & rsp_in_ready & !(thru & rsp_out_ready);
    assign pop  = rsp_out_valid & rsp_out_ready & !empty;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (push) wp <= (wp == AW'(RSP_DEPTH - 1)) ? '0 : wp + 1'b1;
        if (pop)  rp <= (rp == AW'(RSP_DEPTH - 1)) ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(push) - CW'(pop);
      end
    end

    always_ff @(posedge clk) begin
      if (push) mem[wp] <= rsp_in_data;
    end
  end
endmodule

// File: rtl/bypass_fifo_pair_chk.sv
`timescale 1ns/1ps
module bypass_fifo_pair_chk #(
  parameter int unsigned REQ_W     = 8,
  parameter int unsigned RSP_W     = 8,
  parameter int unsigned SPARE_W   = 1,
  parameter bit          REQ_PASS  = 1'b1,
  parameter bit          RSP_PASS  = 1'b0,
  parameter int unsigned REQ_DEPTH = 2,
  parameter int unsigned RSP_DEPTH = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_in_valid,
  input logic               req_in_ready,
  input logic [REQ_W-1:0]   req_in_data,
  input logic [SPARE_W-1:0] req_in_spare,
  input logic               req_out_valid,
  input logic               req_out_ready,
  input logic [REQ_W-1:0]   req_out_data,
  input logic [SPARE_W-1:0] req_out_spare,
  input logic               rsp_in_valid,
  input logic               rsp_in_ready,
  input logic [RSP_W-1:0]   rsp_in_data,
  input logic               rsp_out_valid,
  input logic               rsp_out_ready,
  input logic [RSP_W-1:0]   rsp_out_data
);
  logic [5:0] req_occ, rsp_occ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_occ <= '0;
      rsp_occ <= '0;
    end else begin
      req_occ <= req_occ + 6'(req_in_valid & req_in_ready) - 6'(req_out_valid & req_out_ready);
      rsp_occ <= rsp_occ + 6'(rsp_in_valid & rsp_in_ready) - 6'(rsp_out_valid & rsp_out_ready);
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> !req_out_valid && !rsp_out_valid && !req_in_ready && !rsp_in_ready);

  assert_req_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (REQ_PASS && req_occ == 6'd0 && req_in_valid) |->
      req_out_valid && req_out_data == req_in_data && req_out_spare == req_in_spare);

  assert_rsp_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!RSP_PASS && rsp_occ == 6'd0) |-> !rsp_out_valid);

  assert_req_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (REQ_DEPTH > 0) |-> (req_in_ready == (req_occ != 6'(REQ_DEPTH))));

  assert_rsp_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (RSP_DEPTH > 0) |-> (rsp_in_ready == (rsp_occ != 6'(RSP_DEPTH))));

  assert_req_wire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (REQ_DEPTH == 0) |-> req_in_ready == req_out_ready && req_out_data == req_in_data);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (REQ_DEPTH > 0 && req_out_valid && !req_out_ready) |=>
      req_out_valid && $stable(req_out_data) && $stable(req_out_spare));

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (RSP_DEPTH > 0 && rsp_out_valid && !rsp_out_ready) |=>
      rsp_out_valid && $stable(rsp_out_data));
endmodule

bind bypass_fifo_pair bypass_fifo_pair_chk #(
  .REQ_W(REQ_W), .RSP_W(RSP_W), .SPARE_W(SPARE_W),
  .REQ_PASS(REQ_PASS), .RSP_PASS(RSP_PASS),
  .REQ_DEPTH(REQ_DEPTH), .RSP_DEPTH(RSP_DEPTH)
) u_chk (.*);

// File: tb/sim_bypass_fifo_pair.sv
`timescale 1ns/1ps
module sim_bypass_fifo_pair;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic       a_req_in_valid = 0, a_req_out_ready = 0, a_rsp_in_valid = 0, a_rsp_out_ready = 0;
  logic [7:0] a_req_in_data = 0, a_rsp_in_data = 0;
  logic [0:0] a_req_in_spare = 0;
  logic       a_req_in_ready, a_req_out_valid, a_rsp_in_ready, a_rsp_out_valid;
  logic [7:0] a_req_out_data, a_rsp_out_data;
  logic [0:0] a_req_out_spare;

  logic       b_req_in_valid = 0, b_req_out_ready = 0, b_rsp_in_valid = 0, b_rsp_out_ready = 0;
  logic [7:0] b_req_in_data = 0, b_rsp_in_data = 0;
  logic [0:0] b_req_in_spare = 0;
  logic       b_req_in_ready, b_req_out_valid, b_rsp_in_ready, b_rsp_out_valid;
  logic [7:0] b_req_out_data, b_rsp_out_data;
  logic [0:0] b_req_out_spare;

  bypass_fifo_pair u0 (
    .clk(clk), .rst_n(rst_n),
    .req_in_valid(a_req_in_valid), .req_in_ready(a_req_in_ready),
    .req_in_data(a_req_in_data), .req_in_spare(a_req_in_spare),
    .req_out_valid(a_req_out_valid), .req_out_ready(a_req_out_ready),
    .req_out_data(a_req_out_data), .req_out_spare(a_req_out_spare),
    .rsp_in_valid(a_rsp_in_valid), .rsp_in_ready(a_rsp_in_ready),
    .rsp_in_data(a_rsp_in_data),
    .rsp_out_valid(a_rsp_out_valid), .rsp_out_ready(a_rsp_out_ready),
    .rsp_out_data(a_rsp_out_data));

  bypass_fifo_pair #(.REQ_PASS(1'b1), .REQ_DEPTH(0), .RSP_PASS(1'b1), .RSP_DEPTH(16)) u1 (
    .clk(clk), .rst_n(rst_n),
    .req_in_valid(b_req_in_valid), .req_in_ready(b_req_in_ready),
    .req_in_data(b_req_in_data), .req_in_spare(b_req_in_spare),
    .req_out_valid(b_req_out_valid), .req_out_ready(b_req_out_ready),
    .req_out_data(b_req_out_data), .req_out_spare(b_req_out_spare),
    .rsp_in_valid(b_rsp_in_valid), .rsp_in_ready(b_rsp_in_ready),
    .rsp_in_data(b_rsp_in_data),
    .rsp_out_valid(b_rsp_out_valid), .rsp_out_ready(b_rsp_out_ready),
    .rsp_out_data(b_rsp_out_data));

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic drive(int sel, logic v, logic [7:0] d, logic r);
    case (sel)
      0: begin a_req_in_valid = v; a_req_in_data = d; a_req_in_spare = d[0]; a_req_out_ready = r; end
      1: begin a_rsp_in_valid = v; a_rsp_in_data = d; a_rsp_out_ready = r; end
      default: begin b_rsp_in_valid = v; b_rsp_in_data = d; b_rsp_out_ready = r; end
    endcase
  endtask

  task automatic sample(int sel, output logic ir, output logic ov, output logic [7:0] od, output logic os);
    case (sel)
      0: begin ir = a_req_in_ready; ov = a_req_out_valid; od = a_req_out_data; os = a_req_out_spare[0]; end
      1: begin ir = a_rsp_in_ready; ov = a_rsp_out_valid; od = a_rsp_out_data; os = a_rsp_out_data[0]; end
      default: begin ir = b_rsp_in_ready; ov = b_rsp_out_valid; od = b_rsp_out_data; os = b_rsp_out_data[0]; end
    endcase
  endtask

  task automatic t_reset();
    a_req_in_valid = 1; a_rsp_in_valid = 1; a_req_out_ready = 1; a_rsp_out_ready = 1;
    b_req_in_valid = 1; b_req_out_ready = 1;
    @(negedge clk);
    check_eq("R1 req_out_valid in reset", a_req_out_valid, 0);
    check_eq("R1 rsp_out_valid in reset", a_rsp_out_valid, 0);
    check_eq("R1 req_in_ready in reset", a_req_in_ready, 0);
    check_eq("R1 rsp_in_ready in reset", a_rsp_in_ready, 0);
    check_eq("R1 wire valid in reset", b_req_out_valid, 0);
    a_req_in_valid = 0; a_rsp_in_valid = 0; b_req_in_valid = 0;
    a_req_out_ready = 0; a_rsp_out_ready = 0; b_req_out_ready = 0;
    step();
    rst_n = 1;
    step();
    @(negedge clk);
    check_eq("R1 req_out_valid after reset", a_req_out_valid, 0);
    check_eq("R1 rsp_out_valid after reset", a_rsp_out_valid, 0);
    check_eq("R1 req_in_ready after reset", a_req_in_ready, 1);
  endtask

  task automatic t_pass();
    step();
    drive(0, 1, 8'hA5, 1);
    @(negedge clk);
    check_eq("R2 same-cycle valid", a_req_out_valid, 1);
    check_eq("R2 same-cycle data", a_req_out_data, 8'hA5);
    check_eq("R8 sideband passes", a_req_out_spare, 1);
    step();
    drive(0, 0, 8'h00, 1);
    @(negedge clk);
    check_eq("R6 bypassed entry not stored", a_req_out_valid, 0);
    step();
    drive(0, 0, 8'h00, 0);
  endtask

  task automatic t_latency();
    step();
    drive(1, 1, 8'h3C, 1);
    @(negedge clk);
    check_eq("R3 not visible in accept cycle", a_rsp_out_valid, 0);
    step();
    drive(1, 0, 8'h00, 1);
    @(negedge clk);
    check_eq("R3 visible next cycle", a_rsp_out_valid, 1);
    check_eq("R3 data", a_rsp_out_data, 8'h3C);
    step();
    @(negedge clk);
    check_eq("R3 gone after pop", a_rsp_out_valid, 0);
    drive(1, 0, 8'h00, 0);
  endtask

  task automatic t_full_indep();
    step();
    for (int i = 0; i < 3; i++) begin
      drive(1, 1, 8'(50 + i), 0);
      step();
    end
    drive(1, 1, 8'd99, 0);
    drive(0, 1, 8'd77, 1);
    @(negedge clk);
    check_eq("R5 ready low at depth", a_rsp_in_ready, 0);
    check_eq("R11 head held", a_rsp_out_data, 50);
    check_eq("R11 head valid", a_rsp_out_valid, 1);
    check_eq("R9 req pass while rsp full", a_req_out_valid, 1);
    check_eq("R9 req data while rsp full", a_req_out_data, 77);
    step();
    drive(0, 0, 8'd0, 0);
    drive(1, 0, 8'd0, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_eq("R4 drain valid", a_rsp_out_valid, 1);
      check_eq("R4 drain data", a_rsp_out_data, 50 + i);
      step();
    end
    @(negedge clk);
    check_eq("R4 no duplicate", a_rsp_out_valid, 0);
    drive(1, 0, 8'd0, 0);
  endtask

  task automatic t_wire();
    step();
    b_req_in_valid = 1; b_req_in_data = 8'h5A; b_req_in_spare = 1; b_req_out_ready = 0;
    @(negedge clk);
    check_eq("R7 ready follows downstream low", b_req_in_ready, 0);
    check_eq("R7 valid passes", b_req_out_valid, 1);
    check_eq("R7 data passes", b_req_out_data, 8'h5A);
    check_eq("R7 sideband passes", b_req_out_spare, 1);
    step();
    b_req_out_ready = 1;
    @(negedge clk);
    check_eq("R7 ready follows downstream high", b_req_in_ready, 1);
    step();
    b_req_in_valid = 0; b_req_out_ready = 0;
  endtask

  task automatic t_deep();
    step();
    for (int i = 0; i < 17; i++) begin
      drive(2, 1, 8'(i + 100), 0);
      @(negedge clk);
      check_eq("R10 ready while filling", b_rsp_in_ready, (i < 16) ? 1 : 0);
      step();
    end
    drive(2, 0, 8'd0, 1);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      check_eq("R10 drain data", b_rsp_out_data, i + 100);
      step();
    end
    @(negedge clk);
    check_eq("R10 empty after drain", b_rsp_out_valid, 0);
    drive(2, 0, 8'd0, 0);
  endtask

  task automatic stream(int sel, int n, int pat);
    logic [7:0] exp_q[$];
    int sent = 0;
    int got = 0;
    int cyc = 0;
    logic ir, ov, os, rdy;
    logic [7:0] od, d;
    step();
    while (got < n && cyc < 3000) begin
      d = 8'(sent * 7 + sel * 40 + pat);
      rdy = (pat == 0) ? 1'b1 : (pat == 1) ? 1'(cyc % 2) : 1'(cyc % 3 == 0);
      drive(sel, sent < n, d, rdy);
      @(negedge clk);
      sample(sel, ir, ov, od, os);
      if (sent < n && ir) begin
        exp_q.push_back(d);
        sent++;
      end
      if (ov && rdy) begin
        if (exp_q.size() == 0) check_eq("R4 unexpected output", od, -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check_eq("R4 order", od, e);
          if (sel == 0) check_eq("R8 sideband with entry", os, e[0]);
        end
        got++;
      end
      step();
      cyc++;
    end
    drive(sel, 0, 8'd0, 0);
    check_eq("R4 delivered count", got, n);
  endtask

  initial begin
    t_reset();
    t_pass();
    t_latency();
    t_full_indep();
    t_wire();
    t_deep();
    for (int p = 0; p < 3; p++) begin
      stream(0, 20, p);
      stream(1, 20, p);
    end
    stream(2, 40, 2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule